// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block interprets the write cycles that a host issues to a parallel NOR-style flash memory. Each cycle that the host qualifies with `wr_en` carries an address and a data word. The decoder follows the multi-cycle command sequences formed by these writes. When a sequence completes, it issues a one-cycle operation request to the program and erase engines: a word program, a chip erase or a sector erase. It also tracks which view the read path must present: array data, autoselect information or the query table.

All standard sequences open with two unlock writes. The host can also switch into a persistent fast-program mode. In that mode a word program takes only two writes, and every other write is ignored until a dedicated two-write exit arrives. A write that breaks a sequence is consumed and sends the decoder back to idle, so the host can restart cleanly with its next write.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset the decoder is idle, `read_mode` is array (0), `bypass_active` is 0, `op_valid` is 0 and `op_kind` is none (0).
- R2: The unlock pair is data AAh at address 555h followed by data 55h at address 2AAh. Commands compare data bits [7:0] and address bits [10:0] only, so higher address and data bits are ignored.
- R3: The unlock pair, then A0h at 555h, then any write produces a program request (`op_kind` 1). `op_addr` and `op_data` hold that final write, and the request appears in the cycle after the final write.
- R4: The unlock pair followed by 20h at 555h sets `bypass_active` in the cycle after that write.
- R5: While `bypass_active` is set, A0h at any address followed by any write produces a program request for the second write. The pair may be repeated any number of times without unlocking.
- R6: While `bypass_active` is set, every write other than the A0h lead-in or the 90h exit lead-in is ignored: no request, no change of read mode, and the mode stays active. This includes F0h and unlock writes. If 90h is followed by a write other than 00h, the mode stays active.
- R7: While `bypass_active` is set, 90h followed by 00h (at any addresses) clears `bypass_active` and sets `read_mode` to array.
- R8: The unlock pair, 80h at 555h, the unlock pair again, then 10h at 555h produces a chip erase request (`op_kind` 2).
- R9: The same five-write prefix followed by 30h at any address produces a sector erase request (`op_kind` 3), with `op_addr` equal to that address.
- R10: The unlock pair followed by 90h at 555h sets `read_mode` to autoselect (1).
- R11: At idle, 98h at address 55h sets `read_mode` to query (2), starting from array or autoselect.
- R12: At idle, F0h at any address sets `read_mode` to array.
- R13: Outside the fast-program mode, a write that does not match the next expected write of a sequence is consumed. It returns the decoder to idle with no request and no change of read mode.
- R14: `op_valid` is a single-cycle pulse and is high exactly when `op_kind` is not none. `read_mode` never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Qualifies one host write cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Data of the write |
| op_valid | output | 1 | One-cycle operation request strobe |
| op_kind | output | 2 | 0 none, 1 program, 2 chip erase, 3 sector erase |
| op_addr | output | ADDR_W | Target address of the last request |
| op_data | output | DATA_W | Program data of the last request |
| read_mode | output | 2 | 0 array, 1 autoselect, 2 query |
| bypass_active | output | 1 | Fast-program mode is active |

## Verification
All three results of a write are registered once: the request strobe with its kind, address and data, the read mode, and the fast-program flag. Each of them is therefore due in the cycle that follows the write. The bench drives a write at the falling edge and, at the same moment, advances its behavioural model to the values it expects after the next rising edge. It then compares every output two nanoseconds after that rising edge, on every clock including idle ones. A missing pulse, a late pulse or a stray pulse each show up as a mismatch in that exact cycle.

// File: rtl/fcd_pkg.sv
`timescale 1ns/1ps
package fcd_pkg;

    localparam int CMD_AW = 11;

    localparam logic [7:0] CB_KEY_A   = 8'hAA;
    localparam logic [7:0] CB_KEY_B   = 8'h55;
    localparam logic [7:0] CB_PROG    = 8'hA0;
    localparam logic [7:0] CB_BYPASS  = 8'h20;
    localparam logic [7:0] CB_AUTOSEL = 8'h90;
    localparam logic [7:0] CB_SETUP   = 8'h80;
    localparam logic [7:0] CB_CHIP    = 8'h10;
    localparam logic [7:0] CB_SECTOR  = 8'h30;
    localparam logic [7:0] CB_ARRAY   = 8'hF0;
    localparam logic [7:0] CB_QUERY   = 8'h98;
    localparam logic [7:0] CB_LEAVE   = 8'h00;

    localparam logic [CMD_AW-1:0] CA_KEY_A = 11'h555;
    localparam logic [CMD_AW-1:0] CA_KEY_B = 11'h2AA;
    localparam logic [CMD_AW-1:0] CA_QUERY = 11'h055;

    typedef enum logic [1:0] {
        RD_ARRAY   = 2'd0,
        RD_AUTOSEL = 2'd1,
        RD_QUERY   = 2'd2
    } rd_mode_e;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_PROG   = 2'd1,
        OP_CHIP   = 2'd2,
        OP_SECTOR = 2'd3
    } op_kind_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_UNL1,
        S_UNL2,
        S_PROG,
        S_ERS0,
        S_ERS1,
        S_ERS2,
        S_BYP,
        S_BYP_PROG,
        S_BYP_EXIT
    } seq_state_e;

    typedef struct packed {
        logic key_a;
        logic key_b;
        logic prog_at_key;
        logic bypass_at_key;
        logic autosel_at_key;
        logic setup_at_key;
        logic chip_at_key;
        logic any_prog;
        logic any_sector;
        logic any_ninety;
        logic any_zero;
        logic any_array;
        logic query;
    } wr_class_t;

    function automatic logic cmd_at(input logic [7:0] d, input logic [CMD_AW-1:0] a,
                                    input logic [7:0] cd, input logic [CMD_AW-1:0] ca);
        return (d == cd) && (a == ca);
    endfunction

endpackage

// File: rtl/fcd_classify.sv
`timescale 1ns/1ps
module fcd_classify
    import fcd_pkg::*;
(
    input  logic [7:0]        cmd_byte,
    input  logic [CMD_AW-1:0] cmd_addr,
    output wr_class_t         cls
);

    always_comb begin
        cls.key_a          = cmd_at(cmd_byte, cmd_addr, CB_KEY_A,   CA_KEY_A);
        cls.key_b          = cmd_at(cmd_byte, cmd_addr, CB_KEY_B,   CA_KEY_B);
        cls.prog_at_key    = cmd_at(cmd_byte, cmd_addr, CB_PROG,    CA_KEY_A);
        cls.bypass_at_key  = cmd_at(cmd_byte, cmd_addr, CB_BYPASS,  CA_KEY_A);
        cls.autosel_at_key = cmd_at(cmd_byte, cmd_addr, CB_AUTOSEL, CA_KEY_A);
        cls.setup_at_key   = cmd_at(cmd_byte, cmd_addr, CB_SETUP,   CA_KEY_A);
        cls.chip_at_key    = cmd_at(cmd_byte, cmd_addr, CB_CHIP,    CA_KEY_A);
        cls.query          = cmd_at(cmd_byte, cmd_addr, CB_QUERY,   CA_QUERY);
        cls.any_prog       = (cmd_byte == CB_PROG);
        cls.any_sector     = (cmd_byte == CB_SECTOR);
        cls.any_ninety     = (cmd_byte == CB_AUTOSEL);
        cls.any_zero       = (cmd_byte == CB_LEAVE);
        cls.any_array      = (cmd_byte == CB_ARRAY);
    end

endmodule

// File: rtl/fcd_sequencer.sv
`timescale 1ns/1ps
module fcd_sequencer
    import fcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  wr_class_t  cls,
    output op_kind_e   emit,
    output logic       mode_wr,
    output rd_mode_e   mode_val,
    output logic       in_bypass
);

    seq_state_e state_q, state_d;

    always_comb begin
        state_d  = state_q;
        emit     = OP_NONE;
        mode_wr  = 1'b0;
        mode_val = RD_ARRAY;
        if (wr_en) begin
            unique case (state_q)
                S_IDLE: begin
                    if (cls.key_a) begin
                        state_d = S_UNL1;
                    end else if (cls.any_array) begin
                        mode_wr  = 1'b1;
                        mode_val = RD_ARRAY;
                    end else if (cls.query) begin
                        mode_wr  = 1'b1;
                        mode_val = RD_QUERY;
                    end
                end
                S_UNL1: state_d = cls.key_b ? S_UNL2 : S_IDLE;
                S_UNL2: begin
                    state_d = S_IDLE;
                    if (cls.prog_at_key) begin
                        state_d = S_PROG;
                    end else if (cls.bypass_at_key) begin
                        state_d = S_BYP;
                    end else if (cls.setup_at_key) begin
                        state_d = S_ERS0;
                    end else if (cls.autosel_at_key) begin
                        mode_wr  = 1'b1;
                        mode_val = RD_AUTOSEL;
                    end
                end
                S_PROG: begin
                    emit    = OP_PROG;
                    state_d = S_IDLE;
                end
                S_ERS0: state_d = cls.key_a ? S_ERS1 : S_IDLE;
                S_ERS1: state_d = cls.key_b ? S_ERS2 : S_IDLE;
                S_ERS2: begin
                    state_d = S_IDLE;
                    if (cls.chip_at_key) begin
                        emit = OP_CHIP;
                    end else if (cls.any_sector) begin
                        emit = OP_SECTOR;
                    end
                end
                S_BYP: begin
                    if (cls.any_prog) begin
                        state_d = S_BYP_PROG;
                    end else if (cls.any_ninety) begin
                        state_d = S_BYP_EXIT;
                    end
                end
                S_BYP_PROG: begin
                    emit    = OP_PROG;
                    state_d = S_BYP;
                end
                S_BYP_EXIT: begin
                    if (cls.any_zero) begin
                        state_d  = S_IDLE;
                        mode_wr  = 1'b1;
                        mode_val = RD_ARRAY;
                    end else begin
                        state_d = S_BYP;
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign in_bypass = (state_q == S_BYP) || (state_q == S_BYP_PROG) || (state_q == S_BYP_EXIT);

endmodule

// File: rtl/fcd_outreg.sv
`timescale 1ns/1ps
module fcd_outreg
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  op_kind_e          emit,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              mode_wr,
    input  rd_mode_e          mode_val,
    output logic              valid_q,
    output op_kind_e          kind_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output rd_mode_e          mode_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            kind_q  <= OP_NONE;
            addr_q  <= '0;
            data_q  <= '0;
            mode_q  <= RD_ARRAY;
        end else begin
            valid_q <= (emit != OP_NONE);
            kind_q  <= emit;
            if (emit != OP_NONE) begin
                addr_q <= addr_in;
                data_q <= data_in;
            end
            if (mode_wr) begin
                mode_q <= mode_val;
            end
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
`timescale 1ns/1ps
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              op_valid,
    output logic [1:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic [1:0]        read_mode,
    output logic              bypass_active
);

    wr_class_t cls;
    op_kind_e  emit;
    logic      mode_wr;
    rd_mode_e  mode_val;
    op_kind_e  kind_q;
    rd_mode_e  mode_q;

    fcd_classify u_classify (
        .cmd_byte (wr_data[7:0]),
        .cmd_addr (wr_addr[CMD_AW-1:0]),
        .cls      (cls)
    );

    fcd_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .cls       (cls),
        .emit      (emit),
        .mode_wr   (mode_wr),
        .mode_val  (mode_val),
        .in_bypass (bypass_active)
    );

    fcd_outreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .emit     (emit),
        .addr_in  (wr_addr),
        .data_in  (wr_data),
        .mode_wr  (mode_wr),
        .mode_val (mode_val),
        .valid_q  (op_valid),
        .kind_q   (kind_q),
        .addr_q   (op_addr),
        .data_q   (op_data),
        .mode_q   (mode_q)
    );

    assign op_kind   = kind_q;
    assign read_mode = mode_q;

endmodule

// File: rtl/fcd_checker.sv
`timescale 1ns/1ps
module fcd_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] cmd_byte,
    input logic       op_valid,
    input logic [1:0] op_kind,
    input logic [1:0] read_mode,
    input logic       bypass_active
);

    p_pulse_r14: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> !op_valid);

    p_op_after_write_r14: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> $past(wr_en));

    p_kind_matches_valid_r14: assert property (@(posedge clk) disable iff (rst)
        op_valid == (op_kind != 2'd0));

    p_mode_legal_r14: assert property (@(posedge clk) disable iff (rst)
        read_mode != 2'd3);

    p_bypass_entry_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(bypass_active) |-> ($past(wr_en) && $past(cmd_byte) == 8'h20));

    p_bypass_exit_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(bypass_active) |-> ($past(wr_en) && $past(cmd_byte) == 8'h00 && read_mode == 2'd0));

    p_bypass_prog_only_r5: assert property (@(posedge clk) disable iff (rst)
        (bypass_active && op_valid) |-> (op_kind == 2'd1));

    p_bypass_mode_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(bypass_active) && bypass_active) |-> $stable(read_mode));

    p_mode_needs_write_r13: assert property (@(posedge clk) disable iff (rst)
        (read_mode != $past(read_mode)) |-> $past(wr_en));

    p_query_entry_r11: assert property (@(posedge clk) disable iff (rst)
        (read_mode == 2'd2 && $past(read_mode) != 2'd2) |-> ($past(cmd_byte) == 8'h98));

    p_autosel_entry_r10: assert property (@(posedge clk) disable iff (rst)
        (read_mode == 2'd1 && $past(read_mode) != 2'd1) |-> ($past(cmd_byte) == 8'h90));

endmodule

bind flash_cmd_decoder fcd_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .cmd_byte      (wr_data[7:0]),
    .op_valid      (op_valid),
    .op_kind       (op_kind),
    .read_mode     (read_mode),
    .bypass_active (bypass_active)
);

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;

    localparam int AW = 20;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          op_valid;
    logic [1:0]    op_kind;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data;
    logic [1:0]    read_mode;
    logic          bypass_active;

    flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
        .read_mode(read_mode), .bypass_active(bypass_active)
    );

    always #4 clk = ~clk;

    int    vectors = 0;
    int    misses  = 0;
    bit    done    = 0;
    string cur_req = "R1";

    // behavioural model: expected outputs after the next rising edge
    int            stg    = 0;
    logic          e_val  = 1'b0;
    logic [1:0]    e_kind = 2'd0;
    logic [AW-1:0] e_addr = '0;
    logic [DW-1:0] e_data = '0;
    logic [1:0]    e_mode = 2'd0;
    logic          e_byp  = 1'b0;

    function automatic bit is_at(input logic [AW-1:0] a, input logic [DW-1:0] d,
                                 input logic [7:0] cd, input logic [10:0] ca);
        return (d[7:0] == cd) && (a[10:0] == ca);
    endfunction

    task automatic model_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        e_val  = 1'b0;
        e_kind = 2'd0;
        if (stg == 0) begin
            if (is_at(a, d, 8'hAA, 11'h555)) stg = 1;
            else if (d[7:0] == 8'hF0) e_mode = 2'd0;
            else if (is_at(a, d, 8'h98, 11'h055)) e_mode = 2'd2;
        end else if (stg == 1) begin
            stg = is_at(a, d, 8'h55, 11'h2AA) ? 2 : 0;
        end else if (stg == 2) begin
            if (is_at(a, d, 8'hA0, 11'h555)) stg = 3;
            else if (is_at(a, d, 8'h20, 11'h555)) stg = 7;
            else if (is_at(a, d, 8'h80, 11'h555)) stg = 4;
            else begin
                if (is_at(a, d, 8'h90, 11'h555)) e_mode = 2'd1;
                stg = 0;
            end
        end else if (stg == 3) begin
            e_val = 1'b1; e_kind = 2'd1; e_addr = a; e_data = d; stg = 0;
        end else if (stg == 4) begin
            stg = is_at(a, d, 8'hAA, 11'h555) ? 5 : 0;
        end else if (stg == 5) begin
            stg = is_at(a, d, 8'h55, 11'h2AA) ? 6 : 0;
        end else if (stg == 6) begin
            if (is_at(a, d, 8'h10, 11'h555)) begin
                e_val = 1'b1; e_kind = 2'd2; e_addr = a; e_data = d;
            end else if (d[7:0] == 8'h30) begin
                e_val = 1'b1; e_kind = 2'd3; e_addr = a; e_data = d;
            end
            stg = 0;
        end else if (stg == 7) begin
            if (d[7:0] == 8'hA0) stg = 8;
            else if (d[7:0] == 8'h90) stg = 9;
        end else if (stg == 8) begin
            e_val = 1'b1; e_kind = 2'd1; e_addr = a; e_data = d; stg = 7;
        end else begin
            if (d[7:0] == 8'h00) begin
                stg = 0; e_mode = 2'd0;
            end else begin
                stg = 7;
            end
        end
        e_byp = (stg >= 7);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        model_write(a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            wr_addr = $urandom_range(0, (1 << AW) - 1);
            wr_data = 16'h00A0;
            e_val = 1'b0; e_kind = 2'd0;
        end
    endtask

    task automatic unlock();
        wr(20'h00555, 16'h00AA);
        wr(20'h002AA, 16'h0055);
    endtask

    // compare every clock, away from the edge
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            vectors++;
            if (op_valid !== e_val) begin
                misses++;
                $display("FAIL %s: op_valid got %0b expected %0b", cur_req, op_valid, e_val);
            end
            if (op_kind !== e_kind) begin
                misses++;
                $display("FAIL %s: op_kind got %0d expected %0d", cur_req, op_kind, e_kind);
            end
            if (e_val && (op_addr !== e_addr || op_data !== e_data)) begin
                misses++;
                $display("FAIL %s: op addr/data got %h/%h expected %h/%h",
                         cur_req, op_addr, op_data, e_addr, e_data);
            end
            if (read_mode !== e_mode) begin
                misses++;
                $display("FAIL %s: read_mode got %0d expected %0d", cur_req, read_mode, e_mode);
            end
            if (bypass_active !== e_byp) begin
                misses++;
                $display("FAIL %s: bypass_active got %0b expected %0b", cur_req, bypass_active, e_byp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            misses++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state observed on the first compared cycles
        cur_req = "R1";
        idle(2);

        // R3 with R2: standard program, high address bits set on the unlock writes
        cur_req = "R3";
        wr(20'hF0555, 16'h12AA);
        wr(20'h7F2AA, 16'h3455);
        wr(20'h00555, 16'h00A0);
        wr(20'h4C123, 16'hBEEF);
        idle(1);

        // R2 and R13: wrong second-unlock address aborts, then the retry is fresh
        cur_req = "R13";
        wr(20'h00555, 16'h00AA);
        wr(20'h00123, 16'h0055);
        wr(20'h00555, 16'h00A0);
        wr(20'h00777, 16'h1111);
        idle(1);
        cur_req = "R2";
        wr(20'h00555, 16'h00AA);
        wr(20'h002AA, 16'h0056);
        wr(20'h00555, 16'h00A0);
        wr(20'h00778, 16'h2222);
        idle(2);

        // R8: chip erase
        cur_req = "R8";
        unlock(); wr(20'h00555, 16'h0080); unlock(); wr(20'h00555, 16'h0010);
        idle(1);

        // R9: sector erase, address selects the sector
        cur_req = "R9";
        unlock(); wr(20'h00555, 16'h0080); unlock(); wr(20'h4A000, 16'h0030);
        idle(1);
        // R13: erase prefix broken by a wrong fifth write
        cur_req = "R13";
        unlock(); wr(20'h00555, 16'h0080); wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0054);
        wr(20'h4A000, 16'h0030);
        idle(1);

        // R10: autoselect, then R11 query from autoselect
        cur_req = "R10";
        unlock(); wr(20'h00555, 16'h0090);
        idle(1);
        cur_req = "R11";
        wr(20'h00055, 16'h0098);
        idle(1);
        // R13: F0 inside a sequence is a mismatch, read mode untouched
        cur_req = "R13";
        wr(20'h00555, 16'h00AA);
        wr(20'h00100, 16'h00F0);
        idle(1);
        // R12: F0 at idle returns to array
        cur_req = "R12";
        wr(20'h12345, 16'h00F0);
        idle(1);
        // R11: query from array, wrong address ignored first
        cur_req = "R11";
        wr(20'h00056, 16'h0098);
        wr(20'h80055, 16'h0098);
        idle(1);
        cur_req = "R12";
        wr(20'h00000, 16'h00F0);

        // R4: enter fast-program mode
        cur_req = "R4";
        unlock(); wr(20'h00555, 16'h0020);
        idle(1);
        // R5: repeated two-write programs
        cur_req = "R5";
        wr(20'h00000, 16'h00A0); wr(20'h01000, 16'hA5A5);
        wr(20'h33333, 16'h00A0); wr(20'h01001, 16'h5A5A);
        idle(1);
        wr(20'h00555, 16'h00A0);
        idle(2);
        wr(20'hFFFFF, 16'h0000);
        idle(1);
        // R6: ignored writes in fast-program mode
        cur_req = "R6";
        wr(20'h00000, 16'h00F0);
        unlock();
        wr(20'h00055, 16'h0098);
        wr(20'h00555, 16'h0010);
        wr(20'h00000, 16'h0090); wr(20'h00000, 16'h0055);
        idle(1);
        cur_req = "R5";
        wr(20'h00000, 16'h00A0); wr(20'h02000, 16'h0F0F);
        // R7: exit at arbitrary addresses
        cur_req = "R7";
        wr(20'h5A5A5, 16'hFF90); wr(20'hA5A5A, 16'h1200);
        idle(1);
        // R13: after exit, a bare A0 pair no longer programs
        cur_req = "R13";
        wr(20'h00555, 16'h00A0); wr(20'h03000, 16'h7777);
        idle(2);
        // R14: pulse shape covered by the every-cycle compare across a final program
        cur_req = "R14";
        unlock(); wr(20'h00555, 16'h00A0); wr(20'h0ABCD, 16'hC3C3);
        idle(3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule